// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the hazard controller of a five-stage, strictly in-order integer pipeline with the stages fetch, decode, execute, memory and writeback. It has no internal state. It reads the register indices and control flags that the pipeline registers carry and drives, in the same cycle, the operand bypass selects for the execute-stage ALU, the enables of the program counter and the decode register, and the clear inputs of the decode and execute registers.

Instructions never reorder, so only read-after-write hazards need handling. An ALU result still in the memory or writeback stage is bypassed into execute. A load sitting in execute cannot supply its data to the instruction right behind it, so the front of the pipeline holds for a cycle and a bubble enters execute. Branches are speculated as taken and resolved in execute, and a wrong guess clears the two younger stages. Instruction memory has a single port and can also serve data pointers. When the memory stage borrows that port, fetch waits one cycle and decode receives a bubble in place of the instruction that could not be fetched.

Top module: `hz_ctrl`

## Requirements
- R1: When the memory stage writes (mem_wr_en=1) a nonzero register equal to an execute-stage source, that operand's select is 2'b10 (memory-stage ALU result).
- R2: When only the writeback stage writes (wb_wr_en=1) a nonzero register equal to an execute-stage source, that operand's select is 2'b01 (writeback result).
- R3: When both the memory and writeback stages match the same source, the select is 2'b10, because the memory stage holds the newer value.
- R4: A destination index of 0, or a deasserted write flag, never produces a bypass: the select stays 2'b00 (register-file value). A load with destination 0 never causes a stall.
- R5: A load in execute whose nonzero destination equals either decode-stage source causes a load-use stall: fetch_en=0, decode_en=0, execute_flush=1, decode_flush=0.
- R6: A load in execute whose destination matches neither decode source, or a non-load instruction with a matching destination, causes no stall.
- R7: A misprediction sets decode_flush=1 and execute_flush=1 and forces fetch_en=1 and decode_en=1, whatever stall is requested in the same cycle.
- R8: A memory-stage read of instruction memory with no load-use hazard gives fetch_en=0, decode_en=1, decode_flush=1, execute_flush=0.
- R9: An instruction-memory borrow together with a load-use stall gives fetch_en=0, decode_en=0, decode_flush=0, execute_flush=1, so the held decode instruction is kept.
- R10: With no hazard, both selects are 2'b00, both enables are 1 and both flushes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source index of the decode-stage instruction |
| id_rs2 | input | 5 | Second source index of the decode-stage instruction |
| ex_rs1 | input | 5 | First source index of the execute-stage instruction |
| ex_rs2 | input | 5 | Second source index of the execute-stage instruction |
| ex_rd | input | 5 | Destination index of the execute-stage instruction |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_mispredict | input | 1 | Branch resolved in execute disagrees with the prediction |
| mem_rd | input | 5 | Destination index of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_imem_rd | input | 1 | Memory-stage instruction reads the shared instruction memory |
| wb_rd | input | 5 | Destination index of the writeback-stage instruction |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| fwd_a | output | 2 | Select for ALU operand A (00 register file, 10 memory stage, 01 writeback) |
| fwd_b | output | 2 | Select for ALU operand B, same coding |
| fetch_en | output | 1 | Program-counter enable, low to stall fetch |
| decode_en | output | 1 | Decode-register enable, low to hold decode |
| decode_flush | output | 1 | Clears the decode register |
| execute_flush | output | 1 | Clears the execute register |

## Verification
Several functions can fall in the same cycle: a misprediction can arrive while a load-use stall is requested, and an instruction-memory borrow can coincide with a load-use stall. The bench sets up the load-use condition first and then raises the misprediction or borrow flag in the same stimulus. It expects the flush to win over the stall in the first case (R7), and in the second case it expects both stalls held with no decode clear (R9). Bypass priority is provoked the same way, by giving the memory and writeback stages the same destination (R3).

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned NUM_SRC   = 2;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        reg_idx_t rd;
        logic     wr_en;
    } producer_t;

    typedef struct packed {
        logic fetch_en;
        logic decode_en;
        logic decode_flush;
        logic execute_flush;
    } pipe_ctl_t;

    function automatic logic writes_reg(input producer_t p, input reg_idx_t src);
        return p.wr_en && (p.rd != '0) && (p.rd == src);
    endfunction

endpackage

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
    import hz_pkg::*;
(
    input  reg_idx_t  src,
    input  producer_t mem_prod,
    input  producer_t wb_prod,
    output fwd_sel_e  sel
);
    always_comb begin
        if (writes_reg(mem_prod, src)) begin
            sel = FWD_MEM;
        end else if (writes_reg(wb_prod, src)) begin
            sel = FWD_WB;
        end else begin
            sel = FWD_RF;
        end
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hz_pkg::*;
(
    input  reg_idx_t id_rs1,
    input  reg_idx_t id_rs2,
    input  reg_idx_t ex_rd,
    input  logic     ex_is_load,
    output logic     lu_stall
);
    logic rd_live;

    always_comb begin
        rd_live  = ex_is_load && (ex_rd != '0);
        lu_stall = rd_live && ((ex_rd == id_rs1) || (ex_rd == id_rs2));
    end
endmodule

// File: rtl/hz_flush_arbiter.sv
module hz_flush_arbiter
    import hz_pkg::*;
(
    input  logic      lu_stall,
    input  logic      imem_busy,
    input  logic      mispredict,
    output pipe_ctl_t ctl
);
    always_comb begin
        ctl = '{fetch_en: 1'b1, decode_en: 1'b1, decode_flush: 1'b0, execute_flush: 1'b0};
        if (mispredict) begin
            ctl.decode_flush  = 1'b1;
            ctl.execute_flush = 1'b1;
        end else begin
            if (lu_stall) begin
                ctl.fetch_en      = 1'b0;
                ctl.decode_en     = 1'b0;
                ctl.execute_flush = 1'b1;
            end
            if (imem_busy) begin
                ctl.fetch_en = 1'b0;
                if (!lu_stall) begin
                    ctl.decode_flush = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
(
    input  logic [4:0] id_rs1,
    input  logic [4:0] id_rs2,
    input  logic [4:0] ex_rs1,
    input  logic [4:0] ex_rs2,
    input  logic [4:0] ex_rd,
    input  logic       ex_is_load,
    input  logic       ex_mispredict,
    input  logic [4:0] mem_rd,
    input  logic       mem_wr_en,
    input  logic       mem_imem_rd,
    input  logic [4:0] wb_rd,
    input  logic       wb_wr_en,
    output logic [1:0] fwd_a,
    output logic [1:0] fwd_b,
    output logic       fetch_en,
    output logic       decode_en,
    output logic       decode_flush,
    output logic       execute_flush
);
    producer_t mem_prod;
    producer_t wb_prod;
    reg_idx_t  ex_src [NUM_SRC];
    fwd_sel_e  sel    [NUM_SRC];
    logic      lu_stall;
    pipe_ctl_t ctl;

    assign mem_prod  = '{rd: mem_rd, wr_en: mem_wr_en};
    assign wb_prod   = '{rd: wb_rd,  wr_en: wb_wr_en};
    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_fwd
        hz_operand_fwd u_fwd (
            .src      (ex_src[g]),
            .mem_prod (mem_prod),
            .wb_prod  (wb_prod),
            .sel      (sel[g])
        );
    end

    hz_load_use u_lu (
        .id_rs1     (id_rs1),
        .id_rs2     (id_rs2),
        .ex_rd      (ex_rd),
        .ex_is_load (ex_is_load),
        .lu_stall   (lu_stall)
    );

    hz_flush_arbiter u_arb (
        .lu_stall   (lu_stall),
        .imem_busy  (mem_imem_rd),
        .mispredict (ex_mispredict),
        .ctl        (ctl)
    );

    assign fwd_a         = sel[0];
    assign fwd_b         = sel[1];
    assign fetch_en      = ctl.fetch_en;
    assign decode_en     = ctl.decode_en;
    assign decode_flush  = ctl.decode_flush;
    assign execute_flush = ctl.execute_flush;
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk (
    input logic [4:0] id_rs1,
    input logic [4:0] id_rs2,
    input logic [4:0] ex_rs1,
    input logic [4:0] ex_rd,
    input logic       ex_is_load,
    input logic       ex_mispredict,
    input logic [4:0] mem_rd,
    input logic       mem_wr_en,
    input logic       mem_imem_rd,
    input logic [4:0] wb_rd,
    input logic       wb_wr_en,
    input logic [1:0] fwd_a,
    input logic       fetch_en,
    input logic       decode_en,
    input logic       decode_flush,
    input logic       execute_flush
);
    logic mem_hit_a;
    logic wb_hit_a;
    logic lu_hit;

    always_comb begin
        mem_hit_a = mem_wr_en && (mem_rd == ex_rs1) && (ex_rs1 != 5'd0);
        wb_hit_a  = wb_wr_en && (wb_rd == ex_rs1) && (ex_rs1 != 5'd0);
        lu_hit    = ex_is_load && (ex_rd != 5'd0) && ((ex_rd == id_rs1) || (ex_rd == id_rs2));

        // R1 and R3: a memory-stage producer always wins
        p_mem_bypass_r1: assert (!mem_hit_a || fwd_a == 2'b10);
        p_wb_bypass_r2: assert (!(wb_hit_a && !mem_hit_a) || fwd_a == 2'b01);
        p_zero_never_r4: assert (ex_rs1 != 5'd0 || fwd_a == 2'b00);
        p_lu_hold_r5: assert (!(lu_hit && !ex_mispredict) || (!fetch_en && !decode_en && execute_flush));
        p_flush_wins_r7: assert (!ex_mispredict || (fetch_en && decode_en && decode_flush && execute_flush));
        p_imem_bubble_r8: assert (!(mem_imem_rd && !lu_hit && !ex_mispredict) || (!fetch_en && decode_flush && !execute_flush));
        p_keep_decode_r9: assert (!(mem_imem_rd && lu_hit && !ex_mispredict) || !decode_flush);
        p_quiet_r10: assert ((ex_mispredict || lu_hit || mem_imem_rd) || (fetch_en && decode_en && !decode_flush && !execute_flush));
    end
endmodule

bind hz_ctrl hz_ctrl_chk u_chk (
    .id_rs1        (id_rs1),
    .id_rs2        (id_rs2),
    .ex_rs1        (ex_rs1),
    .ex_rd         (ex_rd),
    .ex_is_load    (ex_is_load),
    .ex_mispredict (ex_mispredict),
    .mem_rd        (mem_rd),
    .mem_wr_en     (mem_wr_en),
    .mem_imem_rd   (mem_imem_rd),
    .wb_rd         (wb_rd),
    .wb_wr_en      (wb_wr_en),
    .fwd_a         (fwd_a),
    .fetch_en      (fetch_en),
    .decode_en     (decode_en),
    .decode_flush  (decode_flush),
    .execute_flush (execute_flush)
);

// File: tb/hz_ctrl_tb_top.sv
module hz_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic ex_is_load, ex_mispredict, mem_wr_en, mem_imem_rd, wb_wr_en;
    logic [1:0] fwd_a, fwd_b;
    logic fetch_en, decode_en, decode_flush, execute_flush;

    hz_ctrl dut_i (
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_is_load(ex_is_load), .ex_mispredict(ex_mispredict),
        .mem_rd(mem_rd), .mem_wr_en(mem_wr_en), .mem_imem_rd(mem_imem_rd),
        .wb_rd(wb_rd), .wb_wr_en(wb_wr_en),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .fetch_en(fetch_en), .decode_en(decode_en),
        .decode_flush(decode_flush), .execute_flush(execute_flush)
    );

    typedef struct {
        string      tag;
        logic [1:0] fa;
        logic [1:0] fb;
        logic [3:0] ctl;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    int   cycles = 0;
    bit   done   = 0;

    function automatic logic [1:0] model_sel(input logic [4:0] s);
        if (mem_wr_en && mem_rd != 0 && mem_rd == s) return 2'b10;
        if (wb_wr_en && wb_rd != 0 && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    // ctl bits: {fetch_en, decode_en, decode_flush, execute_flush}
    function automatic logic [3:0] model_ctl();
        logic lu;
        lu = ex_is_load && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
        if (ex_mispredict) return 4'b1111;
        if (lu) return 4'b0001;
        if (mem_imem_rd) return 4'b0110;
        return 4'b1100;
    endfunction

    task automatic idle();
        id_rs1 = 5'd1; id_rs2 = 5'd2; ex_rs1 = 5'd3; ex_rs2 = 5'd4; ex_rd = 5'd5;
        mem_rd = 5'd6; wb_rd = 5'd7;
        ex_is_load = 0; ex_mispredict = 0; mem_wr_en = 0; mem_imem_rd = 0; wb_wr_en = 0;
    endtask

    task automatic push(input string tag);
        exp_t e;
        e.tag = tag;
        e.fa  = model_sel(ex_rs1);
        e.fb  = model_sel(ex_rs2);
        e.ctl = model_ctl();
        exp_q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            logic [3:0] act;
            e   = exp_q.pop_front();
            act = {fetch_en, decode_en, decode_flush, execute_flush};
            n_cmp++;
            if (fwd_a !== e.fa || fwd_b !== e.fb || act !== e.ctl) begin
                n_bad++;
                $display("FAIL %s: fwd_a=%b fwd_b=%b ctl=%b expected fwd_a=%b fwd_b=%b ctl=%b",
                         e.tag, fwd_a, fwd_b, act, e.fa, e.fb, e.ctl);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        rst = 0;
        #1;
        push("R10 idle");
        // R1: memory-stage bypass on operand A
        idle(); mem_wr_en = 1; mem_rd = 5'd3; push("R1 mem to A");
        idle(); mem_wr_en = 1; mem_rd = 5'd4; push("R1 mem to B");
        // R2: writeback bypass
        idle(); wb_wr_en = 1; wb_rd = 5'd3; push("R2 wb to A");
        idle(); wb_wr_en = 1; wb_rd = 5'd4; mem_wr_en = 1; mem_rd = 5'd3; push("R2 wb B mem A");
        // R3: both match
        idle(); wb_wr_en = 1; wb_rd = 5'd4; mem_wr_en = 1; mem_rd = 5'd4; push("R3 mem wins");
        idle(); ex_rs1 = 5'd9; ex_rs2 = 5'd9; wb_wr_en = 1; wb_rd = 5'd9; mem_wr_en = 1; mem_rd = 5'd9; push("R3 both ops");
        // R4: register zero and disabled writes
        idle(); ex_rs1 = 0; ex_rs2 = 0; mem_wr_en = 1; mem_rd = 0; wb_wr_en = 1; wb_rd = 0; push("R4 x0 no bypass");
        idle(); mem_rd = 5'd3; wb_rd = 5'd4; push("R4 wen low");
        idle(); ex_is_load = 1; ex_rd = 0; id_rs1 = 0; id_rs2 = 0; push("R4 load x0 no stall");
        // R5: load-use
        idle(); ex_is_load = 1; ex_rd = 5'd1; push("R5 lu rs1");
        idle(); ex_is_load = 1; ex_rd = 5'd2; push("R5 lu rs2");
        // R6: no stall cases
        idle(); ex_is_load = 1; ex_rd = 5'd20; push("R6 load no match");
        idle(); ex_rd = 5'd1; push("R6 non-load match");
        // R7: mispredict, alone and over a stall
        idle(); ex_mispredict = 1; push("R7 flush");
        idle(); ex_mispredict = 1; ex_is_load = 1; ex_rd = 5'd1; mem_imem_rd = 1; push("R7 flush over stalls");
        // R8: instruction memory borrow
        idle(); mem_imem_rd = 1; push("R8 imem borrow");
        idle(); mem_imem_rd = 1; mem_wr_en = 1; mem_rd = 5'd3; push("R8 borrow with bypass");
        // R9: borrow with load-use
        idle(); mem_imem_rd = 1; ex_is_load = 1; ex_rd = 5'd2; push("R9 borrow plus lu");
        // sweep of destinations for bypass and stall
        for (int i = 0; i < 32; i++) begin
            idle(); mem_wr_en = 1; mem_rd = i[4:0]; wb_wr_en = 1; wb_rd = 5'(31 - i);
            ex_is_load = 1; ex_rd = i[4:0]; ex_rs1 = 5'd7; ex_rs2 = 5'd24;
            push("R1 R2 R5 sweep");
        end
        idle(); push("R10 idle end");
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule